// File: doc/BRIEF.md
# Dual-Output PWM Counter Slice

This block is a single pulse-width modulation channel. A 16-bit counter steps once per qualified count event and restarts after a programmable limit value. Two compare values set the duty of two outputs, A and B. The counter runs in one of two shapes. In sawtooth mode it counts upward and then restarts at zero. In centre-aligned mode it counts up to the limit and back down again, so the period doubles and the pulses stay centred.

Count events come from an external fractional-divider tick or from the B pin. The tick can run freely or be gated by the B pin level. On the B pin, the counter can also follow rising edges or falling edges. Software reaches four word registers through a plain write/read strobe port. It can load the counter directly. It can also nudge the phase of a running counter by one count in either direction, using commands that clear themselves once they have been applied. A one-cycle wrap pulse feeds interrupt logic elsewhere.

Top module: `pwm_slice`

## Requirements
- R1: After reset, every register reads back as zero, and pwm_a, pwm_b and wrap_pulse are low.
- R2: The bus has four word addresses: 0 control, 1 counter, 2 compare, 3 limit. In the compare word, A occupies bits 15:0 and B occupies bits 31:16. A counter write takes effect at the next clock edge and overrides any step in that cycle. The limit register holds 16 bits. Reads return the addressed word one cycle after bus_rd.
- R3: When control bit 1 is 0 (sawtooth), each step moves the counter to counter+1. When the counter is at or above the limit, the step moves it to 0 instead and wrap_pulse is high for the following cycle.
- R4: When control bit 1 is 1 (centre-aligned), the counter climbs to the limit and then falls back. wrap_pulse is high for one cycle each time a downward step reaches 0. With limit L > 0, the period is 2L steps.
- R5: pwm_a is (counter < compare A) XOR control bit 2. In mode 0, pwm_b is (counter < compare B) XOR control bit 3.
- R6: Control bits 5:4 select the count source. Value 0 steps on each tick. Value 1 steps on a tick only while the synchronised B pin is high.
- R7: Source value 2 steps once per rising edge of pin_b_in, detected after a two-flop synchroniser. While the source value is not 0, pwm_b is held low.
- R8: Source value 3 steps once per falling edge of the synchronised pin_b_in.
- R9: Writing 1 to control bit 6 sets a retard request, which reads back in bit 6. The next count event while enabled is swallowed, and the request then clears. While the channel is disabled the request is held.
- R10: Writing 1 to control bit 7 sets an advance request, which reads back in bit 7. It adds one extra step on a cycle with no count event, but only while the channel is enabled and div_gt1 is high. Until then the request is held.
- R11: When control bit 0 (enable) is 0, the counter does not move except through a direct counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick | input | 1 | Count-enable tick from the fractional divider |
| div_gt1 | input | 1 | High when the divider ratio exceeds 1 |
| pin_b_in | input | 1 | B pin as seen from the pad, asynchronous |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B, held low when B is an input |
| wrap_pulse | output | 1 | One-cycle wrap indication |

## Verification
The hardest situations to reach are the phase commands colliding with the count stream. A retard must land on a real count event. An advance needs a cycle with no event, the channel enabled, and div_gt1 high, all at once. The random phase sends control writes carrying these request bits at random points, while tick, div_gt1 and a slowly toggling B pin vary independently. Directed cases hold div_gt1 low and disable the channel, to show that the requests stay pending and are then applied once conditions allow.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    parameter int CTR_W  = 16;
    parameter int BUS_W  = 32;
    parameter int ADDR_W = 2;
    parameter int NUM_OUT = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMP = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_LIM = 2'd3;

    typedef enum logic [1:0] {
        SRC_FREE  = 2'd0,
        SRC_GATED = 2'd1,
        SRC_RISE  = 2'd2,
        SRC_FALL  = 2'd3
    } src_mode_e;

    // stored settings, bit order matches control word bits 5:0
    typedef struct packed {
        src_mode_e mode;
        logic      inv_b;
        logic      inv_a;
        logic      centred;
        logic      run;
    } cfg_t;

    typedef struct packed {
        logic             wrap;
        logic             down;
        logic [CTR_W-1:0] value;
    } step_t;

    function automatic step_t next_step(
        input logic [CTR_W-1:0] cur,
        input logic             down,
        input logic             centred,
        input logic [CTR_W-1:0] lim
    );
        step_t r;
        r.wrap  = 1'b0;
        r.down  = down;
        r.value = cur;
        if (!centred) begin
            r.down = 1'b0;
            if (cur >= lim) begin
                r.value = '0;
                r.wrap  = 1'b1;
            end else begin
                r.value = cur + 1'b1;
            end
        end else if (lim == '0) begin
            r.value = '0;
            r.down  = 1'b0;
            r.wrap  = 1'b1;
        end else if (!down) begin
            if (cur >= lim) begin
                r.down  = 1'b1;
                r.value = lim - 1'b1;
                r.wrap  = (lim == {{(CTR_W-1){1'b0}}, 1'b1});
            end else begin
                r.value = cur + 1'b1;
            end
        end else begin
            if (cur == '0) begin
                r.down  = 1'b0;
                r.value = {{(CTR_W-1){1'b0}}, 1'b1};
            end else begin
                r.value = cur - 1'b1;
                r.wrap  = (cur == {{(CTR_W-1){1'b0}}, 1'b1});
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pwm_b_sync.sv
module pwm_b_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~prev_q;
    assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic [CTR_W-1:0] lim,
    input  logic             tick,
    input  logic             div_gt1,
    input  logic             b_lvl,
    input  logic             b_rise,
    input  logic             b_fall,
    input  logic             ret_set,
    input  logic             adv_set,
    input  logic             load,
    input  logic [CTR_W-1:0] load_val,
    output logic [CTR_W-1:0] ctr,
    output logic             ret_pend,
    output logic             adv_pend,
    output logic             wrap
);
    logic [CTR_W-1:0] ctr_q;
    logic             down_q, wrap_q, ret_q, adv_q;
    logic             evt, do_ret, do_adv, step_en;
    step_t            nxt;

    always_comb begin
        unique case (cfg.mode)
            SRC_FREE:  evt = tick;
            SRC_GATED: evt = tick & b_lvl;
            SRC_RISE:  evt = b_rise;
            SRC_FALL:  evt = b_fall;
            default:   evt = 1'b0;
        endcase
        evt     = evt & cfg.run;
        do_ret  = ret_q & evt;
        do_adv  = adv_q & cfg.run & div_gt1 & ~evt;
        step_en = (evt & ~do_ret) | do_adv;
        nxt     = next_step(ctr_q, down_q, cfg.centred, lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q  <= '0;
            down_q <= 1'b0;
            wrap_q <= 1'b0;
            ret_q  <= 1'b0;
            adv_q  <= 1'b0;
        end else begin
            if (load) begin
                ctr_q  <= load_val;
                wrap_q <= 1'b0;
            end else if (step_en) begin
                ctr_q  <= nxt.value;
                down_q <= nxt.down;
                wrap_q <= nxt.wrap;
            end else begin
                wrap_q <= 1'b0;
            end
            ret_q <= ret_set | (ret_q & ~do_ret);
            adv_q <= adv_set | (adv_q & ~do_adv);
        end
    end

    assign ctr      = ctr_q;
    assign ret_pend = ret_q;
    assign adv_pend = adv_q;
    assign wrap     = wrap_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pkg::*;
(
    input  logic [CTR_W-1:0]              ctr,
    input  logic [NUM_OUT-1:0][CTR_W-1:0] cmp,
    input  logic [NUM_OUT-1:0]            inv,
    input  logic [NUM_OUT-1:0]            quiet,
    output logic [NUM_OUT-1:0]            pin
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        assign pin[g] = quiet[g] ? 1'b0 : ((ctr < cmp[g]) ^ inv[g]);
    end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tick,
    input  logic              div_gt1,
    input  logic              pin_b_in,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              wrap_pulse
);
    localparam int CFG_W = $bits(cfg_t);

    cfg_t             cfg_q;
    logic [CTR_W-1:0] cmp_a_q, cmp_b_q, lim_q;
    logic [BUS_W-1:0] rdata_q, rd_mux;
    logic             b_lvl, b_rise, b_fall;
    logic [CTR_W-1:0] ctr;
    logic             ret_pend, adv_pend, wrap;
    logic             wr_ctl, wr_cnt;
    logic [NUM_OUT-1:0] lanes;

    assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
    assign wr_cnt = bus_wr && (bus_addr == ADDR_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            lim_q   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADDR_CTL: cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
                ADDR_CMP: begin
                    cmp_a_q <= bus_wdata[CTR_W-1:0];
                    cmp_b_q <= bus_wdata[2*CTR_W-1:CTR_W];
                end
                ADDR_LIM: lim_q <= bus_wdata[CTR_W-1:0];
                default: ;
            endcase
        end
    end

    pwm_b_sync u_sync (
        .clk (clk),
        .rst (rst),
        .pin (pin_b_in),
        .lvl (b_lvl),
        .rise(b_rise),
        .fall(b_fall)
    );

    pwm_count_core u_core (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .lim     (lim_q),
        .tick    (tick),
        .div_gt1 (div_gt1),
        .b_lvl   (b_lvl),
        .b_rise  (b_rise),
        .b_fall  (b_fall),
        .ret_set (wr_ctl & bus_wdata[CFG_W]),
        .adv_set (wr_ctl & bus_wdata[CFG_W+1]),
        .load    (wr_cnt),
        .load_val(bus_wdata[CTR_W-1:0]),
        .ctr     (ctr),
        .ret_pend(ret_pend),
        .adv_pend(adv_pend),
        .wrap    (wrap)
    );

    pwm_out_stage u_out (
        .ctr  (ctr),
        .cmp  ({cmp_b_q, cmp_a_q}),
        .inv  ({cfg_q.inv_b, cfg_q.inv_a}),
        .quiet({(cfg_q.mode != SRC_FREE), 1'b0}),
        .pin  (lanes)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_CTL: rd_mux = {{(BUS_W-CFG_W-2){1'b0}}, adv_pend, ret_pend, cfg_q};
            ADDR_CNT: rd_mux = {{(BUS_W-CTR_W){1'b0}}, ctr};
            ADDR_CMP: rd_mux = {cmp_b_q, cmp_a_q};
            default:  rd_mux = {{(BUS_W-CTR_W){1'b0}}, lim_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata  = rdata_q;
    assign pwm_a      = lanes[0];
    assign pwm_b      = lanes[1];
    assign wrap_pulse = wrap;
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk
    import pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input cfg_t             cfg,
    input logic             div_gt1,
    input logic [CTR_W-1:0] ctr,
    input logic             ret_pend,
    input logic             adv_pend,
    input logic             wrap_pulse,
    input logic             pwm_b,
    input logic             load,
    input logic [CTR_W-1:0] load_val
);
    assert_hold_when_stopped_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !load) |=> (ctr == $past(ctr)));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (ctr == $past(load_val)));

    assert_wrap_lands_zero_R3: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (ctr == '0));

    assert_b_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode != SRC_FREE) |-> !pwm_b);

    assert_retard_held_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_pend && !cfg.run) |=> ret_pend);

    assert_advance_waits_R10: assert property (@(posedge clk) disable iff (rst)
        (adv_pend && !div_gt1) |=> adv_pend);
endmodule

bind pwm_slice pwm_slice_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg_q),
    .div_gt1   (div_gt1),
    .ctr       (ctr),
    .ret_pend  (ret_pend),
    .adv_pend  (adv_pend),
    .wrap_pulse(wrap_pulse),
    .pwm_b     (pwm_b),
    .load      (wr_cnt),
    .load_val  (bus_wdata[CTR_W-1:0])
);

// File: tb/pwm_slice_test.sv
`timescale 1ns/1ps
module pwm_slice_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0, div_gt1 = 1'b0, pin_b_in = 1'b0;
    logic        pwm_a, pwm_b, wrap_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pwm_slice uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .div_gt1(div_gt1), .pin_b_in(pin_b_in),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .wrap_pulse(wrap_pulse)
    );

    // ---------------- reference model from the requirements ----------------
    logic [15:0] m_ctr, m_cmpa, m_cmpb, m_lim;
    logic        m_down, m_wrap, m_ret, m_adv;
    logic        m_run, m_cen, m_ia, m_ib;
    logic [1:0]  m_mode;
    logic        m_b1, m_b2, m_bp;

    // returns {wrap, down, value}
    function automatic logic [17:0] ref_step(logic [15:0] c, logic dn, logic cen, logic [15:0] l);
        if (!cen)              return (c >= l) ? {1'b1, 1'b0, 16'd0} : {1'b0, 1'b0, c + 16'd1};
        if (l == 0)            return {1'b1, 1'b0, 16'd0};
        if (!dn && c >= l)     return {(l == 16'd1), 1'b1, l - 16'd1};
        if (!dn)               return {1'b0, 1'b0, c + 16'd1};
        if (c == 0)            return {1'b0, 1'b0, 16'd1};
        return {(c == 16'd1), 1'b1, c - 16'd1};
    endfunction

    function automatic logic [31:0] ref_read(logic [1:0] a);
        case (a)
            2'd0:    return {24'd0, m_adv, m_ret, m_mode, m_ib, m_ia, m_cen, m_run};
            2'd1:    return {16'd0, m_ctr};
            2'd2:    return {m_cmpb, m_cmpa};
            default: return {16'd0, m_lim};
        endcase
    endfunction

    always @(posedge clk) begin
        logic ev, dr, da;
        logic [17:0] s;
        if (rst) begin
            m_ctr <= 0; m_cmpa <= 0; m_cmpb <= 0; m_lim <= 0;
            m_down <= 0; m_wrap <= 0; m_ret <= 0; m_adv <= 0;
            m_run <= 0; m_cen <= 0; m_ia <= 0; m_ib <= 0; m_mode <= 0;
            m_b1 <= 0; m_b2 <= 0; m_bp <= 0;
        end else begin
            m_b1 <= pin_b_in; m_b2 <= m_b1; m_bp <= m_b2;
            case (m_mode)
                2'd0: ev = tick;
                2'd1: ev = tick & m_b2;
                2'd2: ev = m_b2 & ~m_bp;
                default: ev = ~m_b2 & m_bp;
            endcase
            ev = ev & m_run;
            dr = m_ret & ev;
            da = m_adv & m_run & div_gt1 & ~ev;
            s  = ref_step(m_ctr, m_down, m_cen, m_lim);
            if (bus_wr && bus_addr == 2'd1) begin
                m_ctr <= bus_wdata[15:0]; m_wrap <= 0;
            end else if ((ev & ~dr) | da) begin
                m_ctr <= s[15:0]; m_down <= s[16]; m_wrap <= s[17];
            end else m_wrap <= 0;
            m_ret <= (bus_wr && bus_addr == 2'd0 && bus_wdata[6]) | (m_ret & ~dr);
            m_adv <= (bus_wr && bus_addr == 2'd0 && bus_wdata[7]) | (m_adv & ~da);
            if (bus_wr) case (bus_addr)
                2'd0: {m_mode, m_ib, m_ia, m_cen, m_run} <= bus_wdata[5:0];
                2'd2: {m_cmpb, m_cmpa} <= bus_wdata;
                2'd3: m_lim <= bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clk_step();
        @(negedge clk);
        if (!rst) begin
            chk({31'd0, pwm_a}, {31'd0, (m_ctr < m_cmpa) ^ m_ia}, "R5 pwm_a");
            if (m_mode != 0) chk({31'd0, pwm_b}, 32'd0, "R7 pwm_b held low");
            else chk({31'd0, pwm_b}, {31'd0, (m_ctr < m_cmpb) ^ m_ib}, "R5 pwm_b");
            chk({31'd0, wrap_pulse}, {31'd0, m_wrap}, m_cen ? "R4 wrap" : "R3 wrap");
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        clk_step();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        logic [31:0] e;
        e = ref_read(a);
        bus_rd = 1; bus_addr = a;
        clk_step();
        bus_rd = 0;
        chk(bus_rdata, e, tag);
    endtask

    task automatic rd_fixed(input logic [1:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1; bus_addr = a;
        clk_step();
        bus_rd = 0;
        chk(bus_rdata, e, tag);
    endtask

    function automatic string mode_tag();
        if (m_mode == 1) return "R6 gated count";
        if (m_mode == 2) return "R7 rise count";
        if (m_mode == 3) return "R8 fall count";
        return m_cen ? "R4 centred count" : "R3 sawtooth count";
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 0;
        clk_step();
        // R1 reset state
        chk({29'd0, pwm_a, pwm_b, wrap_pulse}, 32'd0, "R1 outputs after reset");
        for (int a = 0; a < 4; a++) rd_fixed(a[1:0], 32'd0, "R1 register reset");

        // R2 field placement
        wr(2'd2, 32'hBEEF_1234);
        rd_fixed(2'd2, 32'hBEEF_1234, "R2 compare word");
        chk({31'd0, pwm_a}, 32'd1, "R2 A in low half");
        wr(2'd3, 32'h0001_00FF);
        rd_fixed(2'd3, 32'h0000_00FF, "R2 limit width");
        wr(2'd1, 32'h0000_0077);
        rd_fixed(2'd1, 32'h0000_0077, "R2 counter load");

        // R11 disabled counter stays put
        tick = 1;
        repeat (5) clk_step();
        rd_fixed(2'd1, 32'h0000_0077, "R11 stopped counter");

        // R9 retard held while disabled, then swallows one event
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h40);
        repeat (4) clk_step();
        rd_fixed(2'd0, 32'h40, "R9 retard pending while disabled");
        wr(2'd0, 32'h01);                  // enable, tick high every cycle
        repeat (9) clk_step();
        rd(2'd1, "R9 counter after retard");
        rd_fixed(2'd0, 32'h01, "R9 retard cleared");

        // R10 advance waits for div_gt1
        tick = 0; div_gt1 = 0;
        wr(2'd1, 32'd5);
        wr(2'd0, 32'h81);
        repeat (4) clk_step();
        rd_fixed(2'd0, 32'h81, "R10 advance pending");
        rd_fixed(2'd1, 32'd5, "R10 counter unchanged");
        div_gt1 = 1;
        clk_step();
        rd_fixed(2'd1, 32'd6, "R10 advance applied");
        rd_fixed(2'd0, 32'h01, "R10 advance cleared");

        // R4 centred period with limit 3, tick every cycle
        wr(2'd3, 32'd3);
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h03);
        tick = 1;
        repeat (14) clk_step();
        rd(2'd1, "R4 centred position");

        // constrained random mix
        for (int it = 0; it < 50; it++) begin
            logic [5:0] cfg;
            tick = 0;
            cfg = {$urandom_range(0, 3) % 4 == 0 ? 2'd0 : 2'($urandom_range(0, 3)),
                   2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 7) != 0)};
            wr(2'd3, $urandom_range(0, 12));
            wr(2'd2, {16'($urandom_range(0, 14)), 16'($urandom_range(0, 14))});
            if ($urandom_range(0, 1)) wr(2'd1, $urandom_range(0, 15));
            wr(2'd0, {26'd0, cfg});
            for (int c = 0; c < 160; c++) begin
                tick    = ($urandom_range(0, 3) != 0);
                div_gt1 = ($urandom_range(0, 2) != 0);
                if ($urandom_range(0, 5) == 0) pin_b_in = ~pin_b_in;
                if ($urandom_range(0, 24) == 0)
                    wr(2'd0, {24'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), cfg});
                else if (c % 16 == 15)
                    rd(2'd1, mode_tag());
                else
                    clk_step();
            end
            rd(2'd0, "R9 R10 control readback");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule